// File: doc/BRIEF.md
# Masked Pseudo-Random Noise Adder

This block produces the noise waveform for one converter channel. A 12-bit linear feedback shift register steps once for every accepted trigger. Its low bits, kept or cleared under a 4-bit amplitude setting, are added to a 12-bit base value. The sum is registered as the next code for the converter. The base value comes from the channel's holding register.

A trigger is accepted when the enable is high and the trigger input is high on a rising clock edge. The 2-bit waveform select decides what an accepted trigger does. With the noise setting, it steps the register and loads base plus masked noise. With any other setting, it loads the base value unchanged and leaves the register alone. Between accepted triggers the output holds its value, whatever the base and amplitude inputs do. Trigger source selection and the analog converter are outside this block.

Top module: `nz_noise_adder`

## Requirements
- R1: A synchronous active-low reset clears `code_o` to 0 and seeds the shift register to 0xAAA. The first noise trigger after reset therefore yields the successor of 0xAAA (0x555) as the noise value.
- R2: The register steps exactly once per accepted noise trigger, and a trigger held high on consecutive cycles counts once per cycle. One step shifts the state left by one bit. The new bit 0 is the XOR of state bits 11, 5, 3 and 0. The state is never zero.
- R3: The amplitude value N unmasks bits [N:0] of the stepped register value. Any N from 11 to 15 unmasks all 12 bits.
- R4: On an accepted noise trigger, `code_o` becomes `base_i` plus the masked stepped value, and the sum wraps modulo 4096.
- R5: On an accepted trigger with `wave_i` other than 2'b01, `code_o` becomes `base_i` and the register does not step. The value 2'b01 selects noise.
- R6: While `en_i` is low, `trig_i` is ignored: `code_o` and the register keep their values.
- R7: With no trigger, `code_o` holds even when `base_i`, `amp_i` or `wave_i` change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Channel enable; triggers are ignored while low |
| trig_i | input | 1 | Trigger; each high cycle is one event |
| wave_i | input | 2 | Waveform select; 2'b01 selects noise |
| amp_i | input | 4 | Amplitude: highest unmasked noise bit |
| base_i | input | 12 | Base value from the holding register |
| code_o | output | 12 | Registered output code |

## Verification
The hardest case to reach is showing that the register did not step. Its state never appears at the ports, so a non-noise or disabled trigger leaves nothing visible behind. The stimulus therefore follows each such trigger with a full-width noise trigger on a zero base. The output then shows the next state directly, and it must match the sequence continuing from where it left off. Wrap-around is reached with a base of 0xFFF, and each mask boundary is reached by stepping the amplitude through 0, 6, 10, 11 and 15.

// File: rtl/nz_pkg.sv
// Shared types for the noise adder.
package nz_pkg;
    // Waveform select encodings; only NOISE steps the register.
    typedef enum logic [1:0] {
        WAVE_OFF   = 2'b00,
        WAVE_NOISE = 2'b01,
        WAVE_TRI0  = 2'b10,
        WAVE_TRI1  = 2'b11
    } wave_e;
endpackage

// File: rtl/nz_lfsr_core.sv
// Fibonacci shift register that steps once per cycle with step_i high.
// Assumes the tap set in TAPS is maximal-length and SEED is nonzero.
// Exposes the current state and the value it will take on the next step.
module nz_lfsr_core #(
    parameter int              W    = 12,
    parameter logic [W-1:0]    SEED = 12'hAAA,
    parameter logic [W-1:0]    TAPS = 12'h829
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    output logic [W-1:0] state_o,
    output logic [W-1:0] next_o
);
    logic [W-1:0] state_q;
    logic         fb;

    // Feedback bit: parity of the tapped state bits.
    always_comb begin
        fb     = ^(state_q & TAPS);
        next_o = {state_q[W-2:0], fb};
    end

    // State register: seed on reset, advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= SEED;
        else if (step_i) state_q <= next_o;
    end

    assign state_o = state_q;

    // R2: the state never reaches zero.
    assert_state_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
    // R2: no step, no change.
    assert_hold_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(state_q));
    // R2: a step shifts the old state up by one bit.
    assert_shift_on_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> state_q[W-1:1] == $past(state_q[W-2:0]));
endmodule

// File: rtl/nz_mask_gen.sv
// Thermometer mask from the amplitude field: bit i is set when amp_i >= i.
// Amplitudes at or beyond W-1 set every bit.
module nz_mask_gen #(
    parameter int W  = 12,
    parameter int AW = 4
) (
    input  logic [AW-1:0] amp_i,
    output logic [W-1:0]  mask_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign mask_o[i] = (32'(amp_i) >= i);
    end

    // R3: the mask is a contiguous run of ones starting at bit 0.
    always_comb begin
        if (!$isunknown(amp_i)) begin
            assert_mask_contig_R3: assert (mask_o[0] && ((mask_o & (mask_o + 1'b1)) == '0));
        end
    end
endmodule

// File: rtl/nz_noise_adder.sv
// Noise adder for one converter channel. On each accepted trigger
// (en_i and trig_i high) with noise selected, it steps the shift register
// and registers base plus the masked stepped value. Other waveform settings
// register the base alone. Assumes trig_i is synchronous to clk.
module nz_noise_adder
    import nz_pkg::*;
#(
    parameter int           DATA_W = 12,
    parameter int           AMP_W  = 4,
    parameter logic [11:0]  SEED   = 12'hAAA,
    parameter logic [11:0]  TAPS   = 12'h829
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              trig_i,
    input  logic [1:0]        wave_i,
    input  logic [AMP_W-1:0]  amp_i,
    input  logic [DATA_W-1:0] base_i,
    output logic [DATA_W-1:0] code_o
);
    logic              accept;
    logic              noise_sel;
    logic              step;
    logic [DATA_W-1:0] lfsr_now;
    logic [DATA_W-1:0] lfsr_next;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] code_q;

    // Trigger qualification and mode decode.
    always_comb begin
        accept    = en_i && trig_i;
        noise_sel = (wave_e'(wave_i) == WAVE_NOISE);
        step      = accept && noise_sel;
    end

    nz_lfsr_core #(.W(DATA_W), .SEED(DATA_W'(SEED)), .TAPS(DATA_W'(TAPS))) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step),
        .state_o (lfsr_now),
        .next_o  (lfsr_next)
    );

    nz_mask_gen #(.W(DATA_W), .AW(AMP_W)) u_mask (
        .amp_i  (amp_i),
        .mask_o (mask)
    );

    // Output register: load on accepted trigger, modulo-2^W sum in noise mode.
    always_ff @(posedge clk) begin
        if (!rst_n)         code_q <= '0;
        else if (step)      code_q <= base_i + (lfsr_next & mask);
        else if (accept)    code_q <= base_i;
    end

    assign code_o = code_q;

    // R6/R7: the output holds without an accepted trigger.
    assert_hold_no_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(code_o));
    // R5: a non-noise trigger loads the base unchanged.
    assert_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !noise_sel) |=> code_o == $past(base_i));
    // R3/R4: after a noise trigger the offset from the base fits inside the mask.
    assert_offset_in_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((code_o - $past(base_i)) & ~$past(mask)) == '0);
    // R5: a non-noise trigger leaves the register alone.
    assert_no_step_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !noise_sel) |=> $stable(lfsr_now));
endmodule

// File: tb/nz_noise_adder_tb.sv
`timescale 1ns/1ps
module nz_noise_adder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic        trig_i = 1'b0;
    logic [1:0]  wave_i = 2'b00;
    logic [3:0]  amp_i = 4'd0;
    logic [11:0] base_i = 12'd0;
    logic [11:0] code_o;

    always #2.5 clk = ~clk;

    nz_noise_adder dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .trig_i(trig_i),
        .wave_i(wave_i), .amp_i(amp_i), .base_i(base_i), .code_o(code_o)
    );

    typedef struct {
        logic [11:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    logic [11:0] lfsr_m;
    logic [11:0] out_m;
    bit          finished = 0;

    // Model of one register step as stated in R2.
    function automatic logic [11:0] step_m(input logic [11:0] s);
        return {s[10:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
    endfunction

    // Mask as stated in R3.
    function automatic logic [11:0] mask_m(input logic [3:0] a);
        if (a >= 4'd11) return 12'hFFF;
        return 12'((13'd1 << (a + 1)) - 13'd1);
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected output.
    task automatic drive(input bit en, input bit trig, input logic [1:0] wv,
                         input logic [3:0] amp, input logic [11:0] base, input string tag);
        item_t it;
        @(negedge clk);
        en_i = en; trig_i = trig; wave_i = wv; amp_i = amp; base_i = base;
        if (en && trig) begin
            if (wv == 2'b01) begin
                lfsr_m = step_m(lfsr_m);
                out_m  = base + (lfsr_m & mask_m(amp));
            end else begin
                out_m = base;
            end
        end
        it.exp = out_m;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compares one queued item per cycle, 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (code_o !== it.exp) begin
                n_fail++;
                $display("FAIL %s: code_o=%03h expected=%03h", it.tag, code_o, it.exp);
            end
        end
    end

    // Watchdog.
    initial begin
        #200000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        lfsr_m = 12'hAAA;
        out_m  = 12'h000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        n_checks++;
        if (code_o !== 12'h000) begin
            n_fail++;
            $display("FAIL R1: code_o=%03h expected=000", code_o);
        end
        // R1: first noise value comes from the seed.
        drive(1, 1, 2'b01, 4'd15, 12'h000, "R1");
        n_checks++;
        if (lfsr_m !== 12'h555) begin
            n_fail++;
            $display("FAIL R1: model step=%03h expected=555", lfsr_m);
        end
        // R2: consecutive triggers step once per cycle.
        for (int k = 0; k < 20; k++) drive(1, 1, 2'b01, 4'd15, 12'h000, "R2");
        // R3: mask boundaries.
        drive(1, 1, 2'b01, 4'd0,  12'h100, "R3");
        drive(1, 1, 2'b01, 4'd6,  12'h100, "R3");
        drive(1, 1, 2'b01, 4'd10, 12'h100, "R3");
        drive(1, 1, 2'b01, 4'd11, 12'h100, "R3");
        drive(1, 1, 2'b01, 4'd12, 12'h100, "R3");
        drive(1, 1, 2'b01, 4'd3,  12'h7F0, "R3");
        // R4: wrap modulo 4096.
        for (int k = 0; k < 4; k++) drive(1, 1, 2'b01, 4'd15, 12'hFFF, "R4");
        drive(1, 1, 2'b01, 4'd15, 12'hF80, "R4");
        // R5: other waveform settings pass the base, register holds.
        drive(1, 1, 2'b00, 4'd15, 12'h123, "R5");
        drive(1, 1, 2'b10, 4'd15, 12'h456, "R5");
        drive(1, 1, 2'b11, 4'd15, 12'h789, "R5");
        drive(1, 1, 2'b01, 4'd15, 12'h000, "R5");
        // R6: disabled triggers are ignored.
        drive(0, 1, 2'b01, 4'd15, 12'h321, "R6");
        drive(0, 1, 2'b00, 4'd15, 12'h654, "R6");
        drive(1, 1, 2'b01, 4'd15, 12'h000, "R6");
        // R7: no trigger, inputs change, output holds.
        drive(1, 0, 2'b01, 4'd2,  12'hABC, "R7");
        drive(1, 0, 2'b00, 4'd9,  12'h0F0, "R7");
        drive(1, 0, 2'b10, 4'd15, 12'hFFF, "R7");
        drive(1, 1, 2'b01, 4'd15, 12'h000, "R7");
        // Idle and drain.
        drive(0, 0, 2'b00, 4'd0, 12'h000, "R7");
        @(negedge clk);
        trig_i = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule